// File: doc/BRIEF.md
# Interrupt Request Gating Controller

This block collects interrupt events from up to nineteen peripheral sources and records each one in a pending-flag register. The flags are gated by a per-source enable mask and a single master enable. The result drives one interrupt line towards the processor. Software reaches the master enable, the mask and the flags through a small word-addressed register port. Pending flags are cleared by writing ones to them.

The block records a flag whether or not its source is enabled. Software can therefore poll causes that it keeps masked, and unmask them later without losing events. A further input carries the processor's own IRQ-disable status bit. A second output is driven only when the gated request is present and that bit is clear, so the block presents the complete three-gate decision: master, mask and processor flag.

Each source input is rising-edge detected by default, so a level that stays high counts as one event. A parameter selects level sensing instead.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset, the master enable, the mask and all flags read 0, and `irq_req_o` and `irq_take_o` are 0.
- R2: The master enable sits in bit 0 of the word at offset 0x208. A write stores bit 0 of the write data, and bits 31:1 read as 0.
- R3: The enable mask sits at offset 0x210, bit k for source k. Bits 31:19 read as 0 and ignore writes.
- R4: A rising edge on `src_i[k]` sets flag bit k at offset 0x214 on that clock edge, whatever the mask and master enable hold. The bit order is: 0 vertical blank, 1 horizontal blank, 2 line match, 3 to 6 timers 0 to 3, 7 to 10 DMA 0 to 3, 11 keypad, 12 cartridge, 13 peer processor, 14 peer send queue empty, 15 peer receive queue holding data, 16 card transfer done, 17 card request, 18 geometry queue.
- R5: A source held high sets its flag only once. After the flag is cleared, it stays clear until the source falls and rises again.
- R6: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R7: When a rising edge and a clear of the same flag bit fall on the same clock edge, the flag is left set.
- R8: `irq_req_o` is 1 exactly one clock after a cycle in which the master enable is 1 and (mask AND flags) is non-zero. Otherwise it is 0.
- R9: `irq_take_o` is 1 only while `irq_req_o` is 1 and `cpu_irq_disable` is 0. It follows `cpu_irq_disable` without a clock.
- R10: Writes to any other offset change no register, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 19 | Peripheral event inputs, one per cause |
| bus_addr | input | 12 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cpu_irq_disable | input | 1 | Processor IRQ-disable status bit |
| irq_req_o | output | 1 | Registered gated interrupt request |
| irq_take_o | output | 1 | Request qualified by the processor flag |

## Verification
The assertions assume that every input changes only between clock edges and that reset is held from time zero, so each past value they compare lies within the cycles since reset. They also assume that a write is one clock wide and addresses a single register. The bench drives all inputs on the falling edge, starts with reset asserted and issues each write as a single-cycle strobe. This keeps the stimulus inside those assumptions. The bench also places a source edge and a clear of the same bit on one rising edge, to reach the collision case without breaking them.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

   // Cause order fixes the bit position in the mask and flag registers
   typedef enum int unsigned {
      SRC_VBLANK = 0, SRC_HBLANK, SRC_LINE_MATCH,
      SRC_TMR0, SRC_TMR1, SRC_TMR2, SRC_TMR3,
      SRC_DMA0, SRC_DMA1, SRC_DMA2, SRC_DMA3,
      SRC_KEYPAD, SRC_CART, SRC_PEER,
      SRC_TXQ_EMPTY, SRC_RXQ_AVAIL,
      SRC_CARD_DONE, SRC_CARD_REQ, SRC_GEOM_Q,
      SRC_COUNT
   } irq_src_e;

   localparam int unsigned DEF_NUM_SRC = int'(SRC_COUNT);

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_MASTER = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_FLAG   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
   parameter int unsigned NUM_SRC     = 19,
   parameter bit          EDGE_DETECT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] event_o
);

   generate
      if (EDGE_DETECT) begin : g_edge
         logic [NUM_SRC-1:0] prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= '0;
            else        prev_q <= src_i;
         end
         assign event_o = src_i & ~prev_q;
      end else begin : g_level
         logic unused_lvl;
         assign unused_lvl = clk ^ rst_n;
         assign event_o    = src_i;
      end
   endgenerate

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import irq_gate_pkg::*;
#(
   parameter int unsigned         ADDR_W     = 12,
   parameter logic [ADDR_W-1:0]   OFS_MASTER = 12'h208,
   parameter logic [ADDR_W-1:0]   OFS_MASK   = 12'h210,
   parameter logic [ADDR_W-1:0]   OFS_FLAG   = 12'h214
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);

   always_comb begin
      if (addr_i == OFS_MASTER)    sel_o = SEL_MASTER;
      else if (addr_i == OFS_MASK) sel_o = SEL_MASK;
      else if (addr_i == OFS_FLAG) sel_o = SEL_FLAG;
      else                         sel_o = SEL_NONE;
   end

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int unsigned NUM_SRC = 19
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] set_i,
   input  logic [NUM_SRC-1:0] clr_i,
   output logic [NUM_SRC-1:0] flag_o
);

   logic [NUM_SRC-1:0] flag_q;

   // Clear first, then set: an event in the clearing cycle survives
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr_i) | set_i;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
   import irq_gate_pkg::*;
#(
   parameter int unsigned       NUM_SRC     = DEF_NUM_SRC,
   parameter int unsigned       ADDR_W      = 12,
   parameter int unsigned       DATA_W      = 32,
   parameter bit                EDGE_DETECT = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_MASTER  = 12'h208,
   parameter logic [ADDR_W-1:0] OFS_MASK    = 12'h210,
   parameter logic [ADDR_W-1:0] OFS_FLAG    = 12'h214
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               cpu_irq_disable,
   output logic               irq_req_o,
   output logic               irq_take_o
);

   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   generate
      if (NUM_SRC < 1 || NUM_SRC >= DATA_W) begin : g_bad_width
         $error("irq_gate_ctrl: NUM_SRC must be between 1 and DATA_W-1");
      end
      if (OFS_MASTER == OFS_MASK || OFS_MASTER == OFS_FLAG || OFS_MASK == OFS_FLAG) begin : g_bad_map
         $error("irq_gate_ctrl: register offsets must differ");
      end
      if ((OFS_MASTER[1:0] | OFS_MASK[1:0] | OFS_FLAG[1:0]) != 2'b00) begin : g_bad_align
         $error("irq_gate_ctrl: register offsets must be word aligned");
      end
   endgenerate

   reg_sel_e           sel;
   logic               master_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] flag_q;
   logic [NUM_SRC-1:0] src_event;
   logic [NUM_SRC-1:0] flag_clr;
   logic               irq_req_q;
   logic               unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

   irq_reg_decode #(
      .ADDR_W    (ADDR_W),
      .OFS_MASTER(OFS_MASTER),
      .OFS_MASK  (OFS_MASK),
      .OFS_FLAG  (OFS_FLAG)
   ) u_decode (
      .addr_i(bus_addr),
      .sel_o (sel)
   );

   irq_src_detect #(
      .NUM_SRC    (NUM_SRC),
      .EDGE_DETECT(EDGE_DETECT)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (src_i),
      .event_o(src_event)
   );

   assign flag_clr = (bus_wr && sel == SEL_FLAG) ? bus_wdata[NUM_SRC-1:0] : '0;

   irq_flag_bank #(
      .NUM_SRC(NUM_SRC)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (src_event),
      .clr_i (flag_clr),
      .flag_o(flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_q <= 1'b0;
         mask_q   <= '0;
      end else if (bus_wr) begin
         if (sel == SEL_MASTER) master_q <= bus_wdata[0];
         if (sel == SEL_MASK)   mask_q   <= bus_wdata[NUM_SRC-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (sel)
         SEL_MASTER: bus_rdata = {{(DATA_W-1){1'b0}}, master_q};
         SEL_MASK:   bus_rdata = {{PAD_W{1'b0}}, mask_q};
         SEL_FLAG:   bus_rdata = {{PAD_W{1'b0}}, flag_q};
         default:    bus_rdata = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_req_q <= 1'b0;
      else        irq_req_q <= master_q & (|(mask_q & flag_q));
   end

   assign irq_req_o  = irq_req_q;
   assign irq_take_o = irq_req_q & ~cpu_irq_disable;

endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
   parameter int unsigned       NUM_SRC    = 19,
   parameter int unsigned       ADDR_W     = 12,
   parameter int unsigned       DATA_W     = 32,
   parameter logic [ADDR_W-1:0] OFS_MASTER = 12'h208,
   parameter logic [ADDR_W-1:0] OFS_FLAG   = 12'h214
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_wr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               cpu_irq_disable,
   input logic               irq_req_o,
   input logic               irq_take_o,
   input logic               master_q,
   input logic [NUM_SRC-1:0] mask_q,
   input logic [NUM_SRC-1:0] flag_q
);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!irq_req_o && flag_q == '0 && !master_q));

   // R3
   rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[DATA_W-1:NUM_SRC] == '0);

   // R2
   master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == OFS_MASTER) |=> $stable(master_q));

   // R8
   irq_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (master_q && (mask_q & flag_q) != '0) |=> irq_req_o);

   // R8
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_q || (mask_q & flag_q) == '0) |=> !irq_req_o);

   // R9
   take_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq_disable |-> !irq_take_o);

   // R9
   take_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take_o |-> irq_req_o);

   generate
      for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
         // R4
         flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_i[k]) |=> flag_q[k]);

         // R6
         flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == OFS_FLAG && bus_wdata[k] && !$rose(src_i[k])) |=> !flag_q[k]);
      end
   endgenerate

endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(
   .NUM_SRC   (NUM_SRC),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .OFS_MASTER(OFS_MASTER),
   .OFS_FLAG  (OFS_FLAG)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .src_i          (src_i),
   .bus_addr       (bus_addr),
   .bus_wr         (bus_wr),
   .bus_wdata      (bus_wdata),
   .bus_rdata      (bus_rdata),
   .cpu_irq_disable(cpu_irq_disable),
   .irq_req_o      (irq_req_o),
   .irq_take_o     (irq_take_o),
   .master_q       (master_q),
   .mask_q         (mask_q),
   .flag_q         (flag_q)
);

// File: tb/irq_gate_ctrl_test.sv
module irq_gate_ctrl_test;

   localparam logic [11:0] A_MASTER = 12'h208;
   localparam logic [11:0] A_MASK   = 12'h210;
   localparam logic [11:0] A_FLAG   = 12'h214;
   localparam logic [11:0] A_HOLE   = 12'h20C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [18:0] src_i = '0;
   logic [11:0] bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cpu_irq_disable = 1'b0;
   logic        irq_req_o;
   logic        irq_take_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   irq_gate_ctrl uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .src_i          (src_i),
      .bus_addr       (bus_addr),
      .bus_wr         (bus_wr),
      .bus_wdata      (bus_wdata),
      .bus_rdata      (bus_rdata),
      .cpu_irq_disable(cpu_irq_disable),
      .irq_req_o      (irq_req_o),
      .irq_take_o     (irq_take_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   task automatic pulse(input int k);
      @(negedge clk);
      src_i[k] = 1'b1;
      @(negedge clk);
      src_i[k] = 1'b0;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(A_MASTER, v); check("R1 master", v, 0);
      rd(A_MASK, v);   check("R1 mask", v, 0);
      rd(A_FLAG, v);   check("R1 flag", v, 0);
      check("R1 irq_req", {31'b0, irq_req_o}, 0);
      check("R1 irq_take", {31'b0, irq_take_o}, 0);
   endtask

   task automatic t_regs();
      logic [31:0] v;
      wr(A_MASTER, 32'hFFFF_FFFF);
      rd(A_MASTER, v); check("R2 master bit0 only", v, 32'h1);
      wr(A_MASTER, 32'hFFFF_FFFE);
      rd(A_MASTER, v); check("R2 master cleared", v, 32'h0);
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, v);   check("R3 mask upper bits", v, 32'h0007_FFFF);
      wr(A_MASK, 32'h0000_0000);
      rd(A_MASK, v);   check("R3 mask cleared", v, 32'h0);
   endtask

   task automatic t_latch_disabled();
      logic [31:0] v;
      pulse(18);
      pulse(11);
      rd(A_FLAG, v); check("R4 flags latch while masked", v, 32'h0004_0800);
      @(negedge clk);
      check("R8 masked no irq", {31'b0, irq_req_o}, 0);
      wr(A_MASK, 32'h0004_0000);
      @(negedge clk); @(negedge clk);
      check("R8 master off no irq", {31'b0, irq_req_o}, 0);
      wr(A_MASTER, 32'h1);
      @(negedge clk);
      check("R8 master on irq", {31'b0, irq_req_o}, 1);
      wr(A_FLAG, 32'h0007_FFFF);
      rd(A_FLAG, v); check("R6 clear all", v, 0);
      @(negedge clk);
      check("R8 irq drops after clear", {31'b0, irq_req_o}, 0);
      wr(A_MASTER, 32'h0);
      wr(A_MASK, 32'h0);
   endtask

   task automatic t_edge_once();
      logic [31:0] v;
      @(negedge clk); src_i[1] = 1'b1;
      @(negedge clk);
      rd(A_FLAG, v); check("R5 first edge sets", v, 32'h2);
      wr(A_FLAG, 32'h2);
      @(negedge clk);
      rd(A_FLAG, v); check("R5 held level no reset", v, 32'h0);
      src_i[1] = 1'b0;
      pulse(1);
      rd(A_FLAG, v); check("R5 new edge sets", v, 32'h2);
      wr(A_FLAG, 32'h2);
   endtask

   task automatic t_w1c();
      logic [31:0] v;
      pulse(3); pulse(7); pulse(16);
      rd(A_FLAG, v); check("R4 timer/dma/card bits", v, 32'h0001_0088);
      wr(A_FLAG, 32'h0000_0080);
      rd(A_FLAG, v); check("R6 clear one bit", v, 32'h0001_0008);
      wr(A_FLAG, 32'h0);
      rd(A_FLAG, v); check("R6 zero write keeps", v, 32'h0001_0008);
      wr(A_FLAG, 32'h0001_0008);
   endtask

   task automatic t_set_wins();
      logic [31:0] v;
      pulse(5);
      @(negedge clk);
      bus_addr  = A_FLAG;
      bus_wdata = 32'h0000_0020;
      bus_wr    = 1'b1;
      src_i[5]  = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
      src_i[5]  = 1'b0;
      rd(A_FLAG, v); check("R7 set wins over clear", v, 32'h0000_0020);
      wr(A_FLAG, 32'h20);
   endtask

   task automatic t_gate();
      wr(A_MASTER, 32'h1);
      wr(A_MASK, 32'h1);
      @(negedge clk); src_i[0] = 1'b1;
      @(negedge clk); src_i[0] = 1'b0;
      check("R8 one cycle latency low", {31'b0, irq_req_o}, 0);
      @(negedge clk);
      check("R8 irq raised", {31'b0, irq_req_o}, 1);
      check("R9 take with cpu enabled", {31'b0, irq_take_o}, 1);
      cpu_irq_disable = 1'b1; #1;
      check("R9 cpu flag blocks", {31'b0, irq_take_o}, 0);
      check("R9 req unaffected", {31'b0, irq_req_o}, 1);
      cpu_irq_disable = 1'b0; #1;
      check("R9 take returns", {31'b0, irq_take_o}, 1);
      wr(A_MASTER, 32'h0);
      check("R8 irq one cycle after master off", {31'b0, irq_req_o}, 1);
      @(negedge clk);
      check("R8 irq off with master", {31'b0, irq_req_o}, 0);
      wr(A_FLAG, 32'h1);
      wr(A_MASK, 32'h0);
   endtask

   task automatic t_hole();
      logic [31:0] v;
      wr(A_MASK, 32'h0000_1000);
      pulse(12);
      wr(A_HOLE, 32'hFFFF_FFFF);
      rd(A_HOLE, v);   check("R10 hole reads zero", v, 0);
      rd(A_MASTER, v); check("R10 master untouched", v, 0);
      rd(A_MASK, v);   check("R10 mask untouched", v, 32'h0000_1000);
      rd(A_FLAG, v);   check("R10 flag untouched", v, 32'h0000_1000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_latch_disabled();
      t_edge_once();
      t_w1c();
      t_set_wins();
      t_gate();
      t_hole();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

endmodule